// File: doc/BRIEF.md
# IPv4 Flow Tuple Hash Unit

This block turns an IPv4 connection tuple (two 32-bit addresses and two 16-bit ports) into a bucket index for a 4096-entry flow table. It accepts one tuple per clock and returns the index one cycle later. The inputs are marked by a strobe, the result by a valid flag, and there is no backpressure in either direction. The mix is fixed and bit-exact, so software that fills the table can compute the same index.

The mix packs the ports into one 32-bit word. It takes the destination address as first operand and the source address as second. A per-bit select between the two operands, steered by the port word, is rotated left by eight bits and XORed with the port word and both operands. The 32-bit result is folded down, its low eleven bits are kept, and that value is doubled. Every index is therefore even, and each bucket owns an adjacent pair of slots. A caller that finds the even slot taken can use the odd one next to it. The protocol number is not part of the hash, and no seed can be programmed.

Top module: `flow_tuple_hash`

## Requirements
- R1: The port word is formed with the source port in bits [31:16] and the destination port in bits [15:0]. An all-zero tuple yields index 0.
- R2: The first mix operand is the destination address and the second is the source address. The select word takes bit i of the first operand where bit i of the port word is 1, and bit i of the second operand where it is 0.
- R3: The mixed word is the port word XOR the first operand XOR the second operand XOR the select word rotated left by 8 bits (bits [23:0] move to [31:8], bits [31:24] move to [7:0]).
- R4: The fold is the mixed word's bits [31:16], shifted down to [15:0], XOR the mixed word's bits [19:0].
- R5: The index is the fold's bits [10:0] placed at index bits [11:1], with index bit 0 always 0. The index is therefore even and at most 4094.
- R6: The output valid equals the input strobe of the previous clock cycle. One new tuple is accepted on every cycle with no gap.
- R7: While the input strobe is low, the index output keeps its last value.
- R8: A synchronous reset clears the output valid and the index to 0 on the next edge, and this overrides a strobe high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Tuple strobe |
| src_addr | input | 32 | Source IPv4 address |
| dst_addr | input | 32 | Destination IPv4 address |
| src_port | input | 16 | Source L4 port |
| dst_port | input | 16 | Destination L4 port |
| out_vld | output | 1 | Index valid, one cycle after the strobe |
| out_idx | output | 12 | Even bucket index |

## Verification
Two functions can land on the same edge. The first is the pair of load and hold: a strobe in one cycle followed at once by a gap, so the index is captured on one edge and must freeze on the next. The second is reset and load: reset is raised while a strobe is high, and reset must win. The bench drives dense streams with random gaps and a mid-stream reset with the strobe held high. It compares valid and index against a behavioural model on every cycle. Directed tuples set the port word to all ones, then to all zeros, and swap the two addresses. This shows the operand order and the select direction separately.

// File: rtl/fth_pkg.sv
package fth_pkg;
    localparam int unsigned FTH_ADDR_W   = 32;
    localparam int unsigned FTH_PORT_W   = 16;
    localparam int unsigned FTH_ROT      = 8;
    localparam int unsigned FTH_FOLD_SH  = 16;
    localparam int unsigned FTH_FOLD_LO  = 20;
    localparam int unsigned FTH_IDX_W    = 12;
endpackage

// File: rtl/fth_port_word.sv
module fth_port_word #(
    parameter int unsigned PORT_W = fth_pkg::FTH_PORT_W,
    localparam int unsigned WORD_W = 2 * PORT_W
) (
    input  logic [PORT_W-1:0] hi_port,
    input  logic [PORT_W-1:0] lo_port,
    output logic [WORD_W-1:0] word
);
    // upper half carries the source port, lower half the destination port
    assign word = {hi_port, lo_port};
endmodule

// File: rtl/fth_mixer.sv
module fth_mixer #(
    parameter int unsigned W   = fth_pkg::FTH_ADDR_W,
    parameter int unsigned ROT = fth_pkg::FTH_ROT
) (
    input  logic [W-1:0] steer,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] mixed
);
    logic [W-1:0] sel_w;
    logic [W-1:0] rot_w;

    // per-bit select: steer bit 1 picks operand A, 0 picks operand B
    for (genvar i = 0; i < W; i++) begin : g_sel
        assign sel_w[i] = steer[i] ? opnd_a[i] : opnd_b[i];
    end

    // rotate left by ROT: low bits move up, top ROT bits wrap to the bottom
    assign rot_w = {sel_w[W-ROT-1:0], sel_w[W-1:W-ROT]};
    assign mixed = steer ^ opnd_a ^ opnd_b ^ rot_w;
endmodule

// File: rtl/fth_fold.sv
module fth_fold #(
    parameter int unsigned W     = fth_pkg::FTH_ADDR_W,
    parameter int unsigned SH    = fth_pkg::FTH_FOLD_SH,
    parameter int unsigned LO_W  = fth_pkg::FTH_FOLD_LO,
    parameter int unsigned OUT_W = fth_pkg::FTH_IDX_W,
    localparam int unsigned HI_W = W - SH,
    localparam int unsigned FW   = (LO_W > HI_W) ? LO_W : HI_W,
    localparam int unsigned KEEP = OUT_W - 1
) (
    input  logic [W-1:0]     mixed,
    output logic [OUT_W-1:0] idx
);
    logic [FW-1:0] hi_x;
    logic [FW-1:0] lo_x;
    logic [FW-1:0] fold_w;

    assign hi_x   = FW'(mixed[W-1:SH]);
    assign lo_x   = FW'(mixed[LO_W-1:0]);
    assign fold_w = hi_x ^ lo_x;
    // keep the low bits and double: every bucket owns an even/odd slot pair
    assign idx    = {fold_w[KEEP-1:0], 1'b0};
endmodule

// File: rtl/flow_tuple_hash.sv
module flow_tuple_hash #(
    parameter int unsigned ADDR_W  = fth_pkg::FTH_ADDR_W,
    parameter int unsigned PORT_W  = fth_pkg::FTH_PORT_W,
    parameter int unsigned ROT     = fth_pkg::FTH_ROT,
    parameter int unsigned FOLD_SH = fth_pkg::FTH_FOLD_SH,
    parameter int unsigned FOLD_LO = fth_pkg::FTH_FOLD_LO,
    parameter int unsigned IDX_W   = fth_pkg::FTH_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [PORT_W-1:0] src_port,
    input  logic [PORT_W-1:0] dst_port,
    output logic              out_vld,
    output logic [IDX_W-1:0]  out_idx
);
    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } hash_state_t;

    logic [ADDR_W-1:0] port_word;
    logic [ADDR_W-1:0] mixed_w;
    logic [IDX_W-1:0]  idx_w;
    hash_state_t       st_d;
    hash_state_t       st_q;

    fth_port_word #(.PORT_W(PORT_W)) u_pw (
        .hi_port (src_port),
        .lo_port (dst_port),
        .word    (port_word)
    );

    // operands swapped on purpose: A is the destination, B the source
    fth_mixer #(.W(ADDR_W), .ROT(ROT)) u_mix (
        .steer  (port_word),
        .opnd_a (dst_addr),
        .opnd_b (src_addr),
        .mixed  (mixed_w)
    );

    fth_fold #(.W(ADDR_W), .SH(FOLD_SH), .LO_W(FOLD_LO), .OUT_W(IDX_W)) u_fold (
        .mixed (mixed_w),
        .idx   (idx_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.idx = idx_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_idx = st_q.idx;
endmodule

// File: rtl/fth_checker.sv
module fth_checker #(
    parameter int unsigned IDX_W = fth_pkg::FTH_IDX_W
) (
    input logic             clk,
    input logic             rst,
    input logic             in_vld,
    input logic             out_vld,
    input logic [IDX_W-1:0] out_idx
);
    logic prev_rst;

    always_ff @(posedge clk) prev_rst <= rst;

    p_strobe_follow_r6: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    p_idle_follow_r6: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    p_even_idx_r5: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_idx[0] == 1'b0));

    p_hold_idx_r7: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(out_idx));

    // R8: state seen after a reset edge must be cleared
    always @(negedge clk) begin
        if (prev_rst === 1'b1) begin
            p_reset_clear_r8: assert (!out_vld && out_idx == '0);
        end
    end
endmodule

bind flow_tuple_hash fth_checker #(.IDX_W(IDX_W)) u_fth_checker (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .out_vld (out_vld),
    .out_idx (out_idx)
);

// File: tb/flow_tuple_hash_bench.sv
module flow_tuple_hash_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [31:0] src_addr = '0;
    logic [31:0] dst_addr = '0;
    logic [15:0] src_port = '0;
    logic [15:0] dst_port = '0;
    logic        out_vld;
    logic [11:0] out_idx;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string cur_req = "R8";

    // reference state
    bit          m_vld = 1'b0;
    int unsigned m_idx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flow_tuple_hash u_flow_tuple_hash (
        .clk(clk), .rst(rst), .in_vld(in_vld),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .src_port(src_port), .dst_port(dst_port),
        .out_vld(out_vld), .out_idx(out_idx)
    );

    // behavioural hash from R1..R5, written with arithmetic
    function automatic int unsigned ref_hash(input longint unsigned sa, input longint unsigned da,
                                             input longint unsigned sp, input longint unsigned dp);
        longint unsigned pw, a, b, sel, rot, x, f;
        pw  = sp * 65536 + dp;                 // R1
        a   = da;                              // R2: destination first
        b   = sa;
        sel = 0;
        for (int i = 0; i < 32; i++) begin
            if (((pw >> i) & 1) == 1) sel += ((a >> i) & 1) << i;
            else                      sel += ((b >> i) & 1) << i;
        end
        rot = ((sel * 256) % 64'h1_0000_0000) + (sel / 64'h100_0000);   // R3
        x   = pw ^ a ^ b ^ rot;
        f   = (x / 65536) ^ (x % 64'h10_0000);                          // R4
        return int'((f % 2048) * 2);                                    // R5
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_vld = 1'b0;
            m_idx = 0;
        end else begin
            m_vld = in_vld;
            if (in_vld) m_idx = ref_hash(src_addr, dst_addr, src_port, dst_port);
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (out_vld !== m_vld || out_idx !== m_idx[11:0]) begin
                errors++;
                $display("FAIL %s: vld=%0b idx=%0d expected vld=%0b idx=%0d",
                         cur_req, out_vld, out_idx, m_vld, m_idx);
            end
            if (out_vld === 1'b1) begin
                checks++;
                if (out_idx[0] !== 1'b0 || out_idx > 12'd4094) begin
                    errors++;
                    $display("FAIL R5: idx=%0d expected even and <=4094", out_idx);
                end
            end
        end
    end

    task automatic drive(input bit v, input logic [31:0] sa, input logic [31:0] da,
                         input logic [15:0] sp, input logic [15:0] dp);
        @(negedge clk);
        in_vld = v; src_addr = sa; dst_addr = da; src_port = sp; dst_port = dp;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run not finished, expected end before %0d cycles", WATCHDOG);
        finish_run();
    end

    initial begin
        cur_req = "R8";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        drive(1, 32'h0, 32'h0, 16'h0, 16'h0);
        drive(0, 32'h0, 32'h0, 16'h0, 16'h0);
        @(negedge clk);
        checks++;
        if (out_idx !== 12'd0) begin
            errors++;
            $display("FAIL R1: idx=%0d expected 0", out_idx);
        end
        cur_req = "R1";
        drive(1, 32'h0, 32'h0, 16'h1234, 16'h0);
        drive(1, 32'h0, 32'h0, 16'h0, 16'h1234);
        cur_req = "R2";
        drive(1, 32'hDEAD_BEEF, 32'h0123_4567, 16'hFFFF, 16'hFFFF);
        drive(1, 32'hDEAD_BEEF, 32'h0123_4567, 16'h0, 16'h0);
        drive(1, 32'h0123_4567, 32'hDEAD_BEEF, 16'hFFFF, 16'hFFFF);
        drive(1, 32'hC0A8_0001, 32'h0A00_0002, 16'hAAAA, 16'h5555);
        drive(1, 32'h0A00_0002, 32'hC0A8_0001, 16'hAAAA, 16'h5555);
        cur_req = "R3";
        drive(1, 32'hFF00_0000, 32'h0, 16'h0, 16'h0);
        drive(1, 32'h0000_00FF, 32'h0, 16'h0, 16'h0);
        cur_req = "R4";
        drive(1, 32'hFFFF_FFFF, 32'h0, 16'h0, 16'h0);
        drive(1, 32'h0, 32'h0, 16'hF000, 16'h0);
        cur_req = "R7";
        drive(1, 32'h1111_2222, 32'h3333_4444, 16'd80, 16'd443);
        drive(0, 32'h9999_9999, 32'h7777_7777, 16'd1, 16'd2);
        drive(0, 32'h5555_5555, 32'h6666_6666, 16'd3, 16'd4);
        cur_req = "R6";
        for (int n = 0; n < 400; n++) begin
            drive(($urandom % 4) != 0, $urandom, $urandom, 16'($urandom), 16'($urandom));
        end
        cur_req = "R8";
        drive(1, 32'hABCD_0123, 32'h4567_89AB, 16'd7, 16'd9);
        rst = 1'b1;
        drive(1, 32'hABCD_0124, 32'h4567_89AC, 16'd8, 16'd10);
        @(negedge clk);
        checks++;
        if (out_vld !== 1'b0 || out_idx !== 12'd0) begin
            errors++;
            $display("FAIL R8: vld=%0b idx=%0d expected vld=0 idx=0", out_vld, out_idx);
        end
        rst = 1'b0;
        cur_req = "R6";
        for (int n = 0; n < 200; n++) begin
            drive(1'b1, $urandom, $urandom, 16'($urandom), 16'($urandom));
        end
        drive(0, 32'h0, 32'h0, 16'h0, 16'h0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule